// File: doc/BRIEF.md
# Multi-Nibble Synchronous Serial Transceiver

This block is the serial shift engine of a small 4-bit processor core. It moves a programmable number of 4-bit nibbles over a clock/data pin pair. On a send it takes them from an internal nibble buffer, and on a receive it writes them into that buffer. The core programs a nibble count and a control word through a narrow write-only register port. It then raises a send or receive start strobe and watches `busy` and `done`. Through its own buffer port the core loads nibbles before a send and reads them back after a receive.

The control word sets several things. It picks which of two pin ports carry the transfer. It decides whether the block makes the serial clock itself, by dividing the system clock, or follows a clock from outside, which passes through a two-flop synchronizer. It also sets which clock edge captures data. A transfer runs on through a core hold, ends at once on a stop request, and is also torn down when both pin ports are switched off. The buffer port is a plain memory port with no handshake: the buffer is storage owned by the core, not a stream. The serial pins cannot be paused, so the interface has no back-pressure.

Top module: `nib_serial_xcvr`

## Requirements
- R1: After reset the control word is 0, so every clock and data output enable is low. The nibble count is 2, so a start with no count written moves exactly 2 nibbles (8 bits).
- R2: `reg_sel` 0 writes the low count nibble, 1 writes the high count nibble and 2 writes the control word; 3 is ignored. The transfer length in nibbles is {high,low}. A count of 0 gives a `done` pulse in the cycle after the start, with no clock activity.
- R3: On a send, bits leave most significant first within a nibble. Nibble n is taken from buffer index n modulo the buffer depth, starting at 0.
- R4: On a receive, each nibble is assembled most significant bit first and stored at buffer index n modulo the depth. No data output enable is raised during a receive.
- R5: Control bit0 = 0 means the clock idles high, data changes on the falling edge and is captured on the rising edge. bit0 = 1 means the clock idles low, data changes on the rising edge and is captured on the falling edge.
- R6: With control bit1 = 0 the block drives the clock. It toggles every `CLK_DIV` system cycles, starting `CLK_DIV` cycles after the start edge, and `done` appears exactly 8·`CLK_DIV`·count cycles after the start edge.
- R7: With control bit1 = 1 the clock pins are not driven. The incoming clock and data each pass two synchronizer flops, and `done` appears 3 cycles after the final capture edge arrives at the pin.
- R8: Control bit3 enables port A (index 0) and bit2 enables port B (index 1). A disabled port has both of its output enables low.
- R9: When control bits 3 and 2 are both 0, a running transfer is dropped: `busy` is low one cycle after the write takes effect and no `done` follows. Start strobes are ignored while both are 0.
- R10: `core_stop` ends a transfer in the next cycle. `busy` goes low, `done` is not raised, the clock returns to its idle level and the data output is released.
- R11: `core_hold` has no effect; a transfer started before or during a hold completes normally.
- R12: `busy` rises in the cycle after an accepted start and falls in the same cycle that `done` is high. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 count low, 1 count high, 2 control) |
| reg_wdata | input | 4 | Register write data |
| start_tx | input | 1 | Send start strobe |
| start_rx | input | 1 | Receive start strobe |
| core_hold | input | 1 | Core hold indication (no effect on transfers) |
| core_stop | input | 1 | Abort request |
| buf_we | input | 1 | Core write into the nibble buffer |
| buf_addr | input | $clog2(BUF_DEPTH) | Nibble buffer address |
| buf_wdata | input | 4 | Nibble buffer write data |
| buf_rdata | output | 4 | Nibble buffer read data (combinational) |
| sclk_i | input | 2 | Serial clock pin inputs, ports A/B |
| sclk_o | output | 2 | Serial clock pin outputs |
| sclk_oe | output | 2 | Serial clock output enables |
| sdat_i | input | 2 | Serial data pin inputs |
| sdat_o | output | 2 | Serial data pin outputs |
| sdat_oe | output | 2 | Serial data output enables |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Outputs are sampled on the falling clock edge, and the bench numbers these samples from the one that follows the edge where the start was taken. In internal-clock mode each clock transition is due `CLK_DIV` samples after the previous one and `done` is due at sample 8·`CLK_DIV`·count. In external-clock mode the bench moves the clock pin itself, and `done` is due three samples after its last capture edge, which accounts for the synchronizer and edge-detect flops. An abort by stop is checked one sample after the request, and an abort by disabling is checked two samples after the register write, one for the register and one for the engine. Every check compares against these exact sample numbers, never against a window.

// File: rtl/nsx_pkg.sv
package nsx_pkg;

  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Control word, MSB first: bit3 port A enable, bit2 port B enable,
  // bit1 external clock, bit0 capture on falling edge.
  typedef struct packed {
    logic en_a;
    logic en_b;
    logic ext_clk;
    logic fall_latch;
  } ctrl_t;

  localparam logic [3:0] CNT_LO_RST = 4'd2;
  localparam logic [3:0] CNT_HI_RST = 4'd0;
  localparam int         NIB_W      = 4;
  localparam int         CNT_W      = 8;

endpackage

// File: rtl/nsx_regs.sv
module nsx_regs
  import nsx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [NIB_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] count
);

  logic [NIB_W-1:0] lo_q;
  logic [NIB_W-1:0] hi_q;
  ctrl_t            ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= CNT_LO_RST;
      hi_q   <= CNT_HI_RST;
      ctrl_q <= '0;
    end else if (we) begin
      unique case (reg_sel_e'(sel))
        SEL_CNT_LO: lo_q   <= wdata;
        SEL_CNT_HI: hi_q   <= wdata;
        SEL_CTRL:   ctrl_q <= ctrl_t'(wdata);
        default:    ;
      endcase
    end
  end

  assign ctrl  = ctrl_q;
  assign count = {hi_q, lo_q};

endmodule

// File: rtl/nsx_clkgen.sv
module nsx_clkgen #(
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_mode,
  input  logic fall_latch,
  input  logic sclk_in,
  output logic launch,
  output logic latch,
  output logic sclk_out
);

  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  // internal divider
  logic [DW-1:0] div_q;
  logic          phase_q;
  logic          int_run;
  logic          tick;

  assign int_run = run & ~ext_mode;
  assign tick    = int_run & (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (!int_run) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      div_q   <= div_q + 1'b1;
    end
  end

  // external clock synchronizer plus one history flop for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;
  logic                 ext_fall;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], sclk_in};
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], sclk_in};
      end
    end
  endgenerate

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign ext_fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];

  logic ext_run;
  assign ext_run = run & ext_mode;

  assign launch = ext_run ? (fall_latch ? ext_rise : ext_fall) : (tick & ~phase_q);
  assign latch  = ext_run ? (fall_latch ? ext_fall : ext_rise) : (tick & phase_q);

  // idle level is high for rising capture, low for falling capture
  assign sclk_out = (int_run & phase_q) ? fall_latch : ~fall_latch;

endmodule

// File: rtl/nsx_shift.sv
module nsx_shift
  import nsx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     stop,
  input  logic                     start_tx,
  input  logic                     start_rx,
  input  logic [CNT_W-1:0]         count,
  input  logic                     launch,
  input  logic                     latch,
  input  logic                     din_raw,
  input  logic                     buf_we,
  input  logic [$clog2(DEPTH)-1:0] buf_addr,
  input  logic [NIB_W-1:0]         buf_wdata,
  output logic [NIB_W-1:0]         buf_rdata,
  output logic                     busy,
  output logic                     rx_mode,
  output logic                     txbit,
  output logic                     done
);

  localparam int AW = $clog2(DEPTH);

  logic [NIB_W-1:0] mem [DEPTH];
  logic [1:0]       din_q;
  logic             busy_q;
  logic             rx_q;
  logic             txbit_q;
  logic             done_q;
  logic [1:0]       bit_q;
  logic [CNT_W-1:0] nib_q;
  logic [CNT_W-1:0] tgt_q;
  logic [2:0]       sh_q;
  logic [AW-1:0]    idx;
  logic [NIB_W-1:0] cur_nib;
  logic [NIB_W-1:0] rx_nib;
  logic             abort;
  logic             last_bit;
  logic             eng_wr;

  assign abort    = ~enable | stop;
  assign idx      = nib_q[AW-1:0];
  assign cur_nib  = mem[idx];
  assign rx_nib   = {sh_q, din_q[1]};
  assign last_bit = latch & (bit_q == 2'd3);
  assign eng_wr   = busy_q & rx_q & last_bit & ~abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= {din_q[0], din_raw};
  end

  always_ff @(posedge clk) begin
    if (eng_wr)      mem[idx]      <= rx_nib;
    else if (buf_we) mem[buf_addr] <= buf_wdata;
  end

  assign buf_rdata = mem[buf_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rx_q    <= 1'b0;
      txbit_q <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      nib_q   <= '0;
      tgt_q   <= '0;
      sh_q    <= '0;
    end else if (abort) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      nib_q   <= '0;
      sh_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_tx || start_rx) begin
          if (count == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            rx_q    <= ~start_tx;
            tgt_q   <= count;
            nib_q   <= '0;
            bit_q   <= '0;
            txbit_q <= 1'b0;
          end
        end
      end else begin
        if (launch && !rx_q) txbit_q <= cur_nib[~bit_q];
        if (latch) begin
          sh_q  <= rx_nib[2:0];
          bit_q <= bit_q + 2'd1;
          if (last_bit) begin
            nib_q <= nib_q + 1'b1;
            if (nib_q + 1'b1 == tgt_q) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign rx_mode = rx_q;
  assign txbit   = txbit_q;
  assign done    = done_q;

endmodule

// File: rtl/nib_serial_xcvr.sv
module nib_serial_xcvr
  import nsx_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int BUF_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_sel,
  input  logic [3:0]                   reg_wdata,
  input  logic                         start_tx,
  input  logic                         start_rx,
  input  logic                         core_hold,
  input  logic                         core_stop,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_DEPTH)-1:0] buf_addr,
  input  logic [3:0]                   buf_wdata,
  output logic [3:0]                   buf_rdata,
  input  logic [1:0]                   sclk_i,
  output logic [1:0]                   sclk_o,
  output logic [1:0]                   sclk_oe,
  input  logic [1:0]                   sdat_i,
  output logic [1:0]                   sdat_o,
  output logic [1:0]                   sdat_oe,
  output logic                         busy,
  output logic                         done
);

  localparam int NPORT = 2;

  ctrl_t            ctrl;
  logic [3:0]       ctrl_bits;
  logic [CNT_W-1:0] count;
  logic             launch;
  logic             latch;
  logic             sclk_int;
  logic             sclk_sel;
  logic             sdat_sel;
  logic             any_en;
  logic             rx_mode;
  logic             txbit;
  logic [NPORT-1:0] port_en;
  logic             unused_hold;

  // a core hold deliberately does not reach the engine
  assign unused_hold = core_hold;
  assign ctrl_bits   = ctrl;
  assign any_en      = ctrl.en_a | ctrl.en_b;
  assign sclk_sel    = ctrl.en_a ? sclk_i[0] : sclk_i[1];
  assign sdat_sel    = ctrl.en_a ? sdat_i[0] : sdat_i[1];

  nsx_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .ctrl  (ctrl),
    .count (count)
  );

  nsx_clkgen #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(2)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy),
    .ext_mode   (ctrl.ext_clk),
    .fall_latch (ctrl.fall_latch),
    .sclk_in    (sclk_sel),
    .launch     (launch),
    .latch      (latch),
    .sclk_out   (sclk_int)
  );

  nsx_shift #(.DEPTH(BUF_DEPTH)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (any_en),
    .stop      (core_stop),
    .start_tx  (start_tx),
    .start_rx  (start_rx),
    .count     (count),
    .launch    (launch),
    .latch     (latch),
    .din_raw   (sdat_sel),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata),
    .buf_rdata (buf_rdata),
    .busy      (busy),
    .rx_mode   (rx_mode),
    .txbit     (txbit),
    .done      (done)
  );

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      if (p == 0) begin : g_a
        assign port_en[p] = ctrl.en_a;
      end else begin : g_b
        assign port_en[p] = ctrl.en_b;
      end
      assign sclk_o[p]  = sclk_int;
      assign sclk_oe[p] = port_en[p] & ~ctrl.ext_clk;
      assign sdat_o[p]  = txbit;
      assign sdat_oe[p] = port_en[p] & busy & ~rx_mode;
    end
  endgenerate

endmodule

// File: rtl/nsx_xcvr_chk.sv
module nsx_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_tx,
  input logic       start_rx,
  input logic       core_hold,
  input logic       core_stop,
  input logic [3:0] ctrl_bits,
  input logic       rx_mode,
  input logic [1:0] sclk_o,
  input logic [1:0] sclk_oe,
  input logic [1:0] sdat_oe,
  input logic       busy,
  input logic       done
);

  a_r12_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r12_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_tx || start_rx));

  a_r10_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    core_stop |=> (!busy && !done));

  a_r9_disable_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_bits[3:2] == 2'b00) |=> (!busy && !done));

  a_r8_port_a_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_bits[3] |-> (!sclk_oe[0] && !sdat_oe[0]));

  a_r8_port_b_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_bits[2] |-> (!sclk_oe[1] && !sdat_oe[1]));

  a_r4_rx_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_mode) |-> (sdat_oe == 2'b00));

  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o[0] == !ctrl_bits[0]));

  a_r7_ext_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_bits[1] |-> (sclk_oe == 2'b00));

  a_r11_hold_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_hold && !core_stop && ctrl_bits[3:2] != 2'b00) |=> (busy || done));

endmodule

bind nib_serial_xcvr nsx_xcvr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_tx  (start_tx),
  .start_rx  (start_rx),
  .core_hold (core_hold),
  .core_stop (core_stop),
  .ctrl_bits (ctrl_bits),
  .rx_mode   (rx_mode),
  .sclk_o    (sclk_o),
  .sclk_oe   (sclk_oe),
  .sdat_oe   (sdat_oe),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_nib_serial_xcvr.sv
module sim_nib_serial_xcvr;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int DEPTH      = 16;
  localparam int AW         = 4;
  localparam int EXT_HALF   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [3:0]    reg_wdata = '0;
  logic          start_tx = 1'b0;
  logic          start_rx = 1'b0;
  logic          core_hold = 1'b0;
  logic          core_stop = 1'b0;
  logic          buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [3:0]    buf_wdata = '0;
  logic [3:0]    buf_rdata;
  logic [1:0]    sclk_i = 2'b11;
  logic [1:0]    sclk_o;
  logic [1:0]    sclk_oe;
  logic [1:0]    sdat_i = '0;
  logic [1:0]    sdat_o;
  logic [1:0]    sdat_oe;
  logic          busy;
  logic          done;

  int n_chk  = 0;
  int n_fail = 0;

  int   mem_img [0:DEPTH-1];
  int   rx_src  [0:255];
  logic got_bits [0:1023];

  nib_serial_xcvr #(.CLK_DIV(DIV), .BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .start_tx(start_tx), .start_rx(start_rx),
    .core_hold(core_hold), .core_stop(core_stop), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdat_i(sdat_i),
    .sdat_o(sdat_o), .sdat_oe(sdat_oe), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_reg(input int sel, input int val);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = 4'(val);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic wr_buf(input int addr, input int val);
    buf_we = 1'b1; buf_addr = AW'(addr); buf_wdata = 4'(val);
    tick();
    buf_we = 1'b0;
  endtask

  function automatic int rx_bit(input int n);
    int v;
    v = rx_src[n / 4];
    return (v >> (3 - (n % 4))) & 1;
  endfunction

  function automatic int tx_expect(input int i);
    return mem_img[i % DEPTH];
  endfunction

  // one full transfer with a bench-side peer model
  task automatic xfer(input bit ext, input bit fall, input int port, input bit rx,
                      input int count, input bit prog, input bit hold,
                      input int abort_at, input bit abort_dis);
    logic [3:0] ctl;
    logic       idle, prev_s, s;
    int dones, done_k, nl, nlat, tog, last_k, limit, chk_k;
    bit drive_flag, other_flag;
    string rq_done;
    idle = !fall;
    ctl = '0;
    ctl[3] = (port == 0);
    ctl[2] = (port == 1);
    ctl[1] = ext;
    ctl[0] = fall;
    sclk_i = {2{idle}};
    sdat_i = '0;
    core_hold = hold;
    wr_reg(2, int'(ctl));
    if (prog) begin
      wr_reg(0, count & 15);
      wr_reg(1, (count >> 4) & 15);
    end
    for (int i = 0; i < DEPTH; i++) begin
      mem_img[i] = int'($urandom % 16);
      wr_buf(i, mem_img[i]);
    end
    for (int i = 0; i < count; i++) rx_src[i] = int'($urandom % 16);
    repeat (4) tick();
    if (!ext)
      check(sclk_o[port] == idle, "R5", "idle clock level", int'(sclk_o[port]), int'(idle));
    if (rx) start_rx = 1'b1; else start_tx = 1'b1;
    tick();
    start_tx = 1'b0; start_rx = 1'b0;
    check(busy == 1'b1, "R12", "busy after start", int'(busy), 1);
    dones = 0; done_k = -1; nl = 0; nlat = 0; tog = 0; last_k = 0;
    drive_flag = 0; other_flag = 0; prev_s = idle;
    rq_done = hold ? "R11" : "R12";
    chk_k = abort_at + (abort_dis ? 2 : 1);
    if (abort_at >= 0) limit = abort_at + 30;
    else if (ext) limit = EXT_HALF * (8 * count + 1) + 10;
    else limit = 8 * DIV * count + 6;
    for (int k = 0; k < limit; k++) begin
      if (done) begin
        dones++;
        if (done_k < 0) done_k = k;
      end
      if (rx && (sdat_oe != 2'b00)) drive_flag = 1;
      if (sclk_oe[1-port] || sdat_oe[1-port]) other_flag = 1;
      if (abort_at >= 0 && k == abort_at + 1) begin
        core_stop = 1'b0;
        reg_we = 1'b0;
      end
      if (abort_at >= 0 && k == chk_k) begin
        check(busy == 1'b0, abort_dis ? "R9" : "R10", "busy after abort", int'(busy), 0);
        check(sdat_oe == 2'b00, abort_dis ? "R9" : "R10", "data enable after abort",
              int'(sdat_oe), 0);
        if (!ext && !abort_dis)
          check(sclk_o[port] == idle, "R10", "clock idle after stop",
                int'(sclk_o[port]), int'(idle));
      end
      if (abort_at < 0 || k < abort_at) begin
        if (!ext) begin
          s = sclk_o[port];
          if (s != prev_s) begin
            if (s != idle) begin
              if (rx && nl < 4 * count) sdat_i[port] = 1'(rx_bit(nl));
              nl++;
            end else begin
              if (!rx) got_bits[nlat] = sdat_o[port];
              nlat++;
            end
          end
          prev_s = s;
        end else if (tog < 8 * count && k >= EXT_HALF && (k % EXT_HALF) == 0) begin
          if ((tog % 2) == 0) begin
            if (rx) sdat_i[port] = 1'(rx_bit(nl));
            nl++;
          end else begin
            if (!rx) got_bits[nlat] = sdat_o[port];
            nlat++;
            last_k = k;
          end
          sclk_i[port] = ~sclk_i[port];
          tog++;
        end
      end
      if (abort_at >= 0 && k == abort_at) begin
        if (abort_dis) begin
          reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 4'd0;
        end else begin
          core_stop = 1'b1;
        end
      end
      tick();
    end
    core_hold = 1'b0;
    if (abort_at < 0) begin
      check(dones == 1, rq_done, "done pulse count", dones, 1);
      if (ext)
        check(done_k == last_k + 3, "R7", "done cycle after last capture", done_k, last_k + 3);
      else begin
        check(done_k == 8 * DIV * count, "R6", "done cycle", done_k, 8 * DIV * count);
        check(nlat == 4 * count, "R2", "capture edges", nlat, 4 * count);
      end
      if (!rx) begin
        for (int i = 0; i < count; i++) begin
          int g;
          g = {28'd0, got_bits[4*i], got_bits[4*i+1], got_bits[4*i+2], got_bits[4*i+3]};
          check(g == tx_expect(i), "R3", $sformatf("sent nibble %0d", i), g, tx_expect(i));
        end
      end else begin
        for (int i = 0; i < count; i++) begin
          buf_addr = AW'(i);
          #1;
          check(int'(buf_rdata) == rx_src[i], "R4", $sformatf("received nibble %0d", i),
                int'(buf_rdata), rx_src[i]);
        end
        check(!drive_flag, "R4", "data enable during receive", int'(drive_flag), 0);
      end
    end else begin
      check(dones == 0, abort_dis ? "R9" : "R10", "done after abort", dones, 0);
    end
    check(!other_flag, "R8", "unselected port enables", int'(other_flag), 0);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_ed07));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    check(sclk_oe == 2'b00, "R1", "clock enables after reset", int'(sclk_oe), 0);
    check(sdat_oe == 2'b00, "R1", "data enables after reset", int'(sdat_oe), 0);
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", int'({busy, done}), 0);

    // R1: default count of 2 nibbles, port A, rising capture
    xfer(0, 0, 0, 0, 2, 0, 0, -1, 0);
    // R2/R3: count 17 via both count registers, buffer wrap, port B, falling capture
    xfer(0, 1, 1, 0, 17, 1, 0, -1, 0);

    // R2: count zero gives an immediate done and no clock activity
    wr_reg(2, 4'b1000);
    wr_reg(0, 0);
    wr_reg(1, 0);
    start_tx = 1'b1;
    tick();
    start_tx = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R2", "zero count done", int'({done, busy}), 2);
    check(sclk_o[0] == 1'b1, "R2", "zero count clock idle", int'(sclk_o[0]), 1);
    tick();
    check(done == 1'b0, "R12", "done width", int'(done), 0);

    // R4/R5: internal receive, both capture edges
    xfer(0, 0, 0, 1, 3, 1, 0, -1, 0);
    xfer(0, 1, 1, 1, 2, 1, 0, -1, 0);
    // R7: external clock, send and receive
    xfer(1, 1, 1, 0, 3, 1, 0, -1, 0);
    xfer(1, 0, 0, 1, 2, 1, 0, -1, 0);
    // R11: hold during transfers
    xfer(0, 0, 0, 0, 2, 1, 1, -1, 0);
    xfer(1, 1, 0, 1, 2, 1, 1, -1, 0);
    // R10: stop aborts
    xfer(0, 0, 0, 0, 4, 1, 0, 50, 0);
    xfer(1, 0, 1, 1, 3, 1, 0, 60, 0);
    // R9: disabling both ports aborts, then starts are ignored
    xfer(0, 1, 0, 1, 3, 1, 0, 40, 1);
    start_tx = 1'b1;
    tick();
    start_tx = 1'b0;
    check(busy == 1'b0 && done == 1'b0, "R9", "start while disabled", int'({busy, done}), 0);
    tick();
    check(sclk_oe == 2'b00 && sdat_oe == 2'b00, "R8", "disabled ports released",
          int'({sclk_oe, sdat_oe}), 0);

    // constrained random transfers
    for (int t = 0; t < 10; t++) begin
      bit ext, fall, rx, hold;
      int port, cnt;
      ext  = 1'($urandom % 2);
      fall = 1'($urandom % 2);
      rx   = 1'($urandom % 2);
      hold = 1'($urandom % 2);
      port = int'($urandom % 2);
      cnt  = 1 + int'($urandom % 4);
      xfer(ext, fall, port, rx, cnt, 1, hold, -1, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule